// File: doc/BRIEF.md
# Issue-Queue Wakeup Entry with Delayed Selective Replay

This block is a single issue-queue slot with two source operands, for a core that issues instructions before the latency of their producers is confirmed. Each operand watches a wakeup broadcast for its source tag. On a match it becomes ready, remembers which issue slot the producer left from, and loads a countdown with the latency carried on the broadcast. Once both operands are ready, the entry raises a request to the select logic.

When a scheduling miss is found, one kill line invalidates every operand whose countdown is still running. This is deliberately conservative: it also hits operands whose producer was fine. Each killed operand then waits for its countdown to expire. In that cycle it reads the completion wire of its producer's issue slot and the scoreboard poison bit for its register. If the producer completed cleanly, the operand becomes ready again. If not, it stays invalid and cannot wake the entry, so wrong speculation stops at this level. It waits for a fresh broadcast when the producer replays.

An entry that has already been granted is cleared back to unissued if a kill removes one of its operands for good, so that it asks to issue again.

Top module: `sr_replay_entry`

## Requirements
- R1: A wakeup broadcast whose tag equals the tag of a non-ready operand makes that operand ready on the next cycle. The same edge loads the operand's countdown with the broadcast latency and records the broadcast issue-slot number.
- R2: When kill is high, every ready operand whose countdown is non-zero becomes not ready. An operand whose countdown is zero keeps its ready state.
- R3: A non-zero countdown falls by one on each clock edge until it reaches zero. A latency of zero loads no countdown, so the operand is never exposed to a kill.
- R4: The expiry cycle is the cycle in which the countdown holds 1. In that cycle the operand samples bit number s of the completion input, where s is its recorded slot. Completion bits at other positions, and completion bits in other cycles, have no effect.
- R5: A killed operand becomes ready again at expiry only if the sampled completion bit is 1 and its poison input is 0. Otherwise it stays not ready until a new matching wakeup arrives.
- R6: A kill in the expiry cycle itself still allows revalidation in that same cycle when the producer completed cleanly. With no completion, the operand ends not ready.
- R7: The request output is high exactly when the entry is allocated, not issued, and both operands are ready.
- R8: A grant while requesting marks the entry issued, which drops the request. A kill that leaves an operand of the entry not ready clears the issued mark, so the entry requests again once its operands are ready.
- R9: A kill and a wakeup in the same cycle are ordered kill first, using the countdown values from before the edge. A matching wakeup in that cycle then makes its operand ready.
- R10: Allocation loads both tags and their initial ready bits, and clears the countdowns and the issued mark. It takes priority over wakeup, kill and grant in the same cycle. A free input drops the request by invalidating the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_i | input | 1 | Write a new instruction into the entry |
| alloc_tag_i | input | 2 x TAG_W | Source tags, index 0 and 1 |
| alloc_rdy_i | input | 2 | Source already available at allocation |
| free_i | input | 1 | Invalidate the entry |
| wake_vld_i | input | 1 | Wakeup broadcast valid |
| wake_tag_i | input | TAG_W | Destination tag being broadcast |
| wake_lat_i | input | LAT_W | Producer latency for the countdown |
| wake_slot_i | input | SLOT_W | Issue slot of the producer |
| kill_i | input | 1 | Conservative invalidation line |
| cmpl_i | input | N_SLOT | One completion wire per issue slot |
| poison_i | input | 2 | Scoreboard poison bit for each operand |
| grant_i | input | 1 | Select logic picked this entry |
| req_o | output | 1 | Entry requests issue |
| opnd_rdy_o | output | 2 | Ready bits of the two operands |

## Verification
The bench uses the default parameters: 6-bit tags, 3-bit countdowns and four issue slots. With these values, latencies from 0 to 3 let kills land on the first, middle and last countdown cycle. The four completion wires let the bench raise every wire except the recorded one, which shows that slot selection matters. Same-cycle kill-and-wake and kill-at-expiry cases are also reachable with these settings.

// File: rtl/sr_pkg.sv
package sr_pkg;

  // Life of one source operand, derived from its ready bit and countdown.
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,  // waiting for a producer broadcast
    PH_SPEC    = 2'd1,  // ready, countdown still running (killable)
    PH_KILLED  = 2'd2,  // invalidated, countdown running toward the check
    PH_SETTLED = 2'd3   // ready and no longer exposed to a kill
  } opnd_phase_e;

  function automatic opnd_phase_e phase_of(input logic rdy, input logic counting);
    if (counting) return rdy ? PH_SPEC : PH_KILLED;
    return rdy ? PH_SETTLED : PH_IDLE;
  endfunction

  localparam int unsigned N_OPND = 2;

endpackage

// File: rtl/sr_operand.sv
module sr_operand
  import sr_pkg::*;
#(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned LAT_W  = 3,
  parameter int unsigned N_SLOT = 4,
  localparam int unsigned SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic              alloc_rdy_i,
  input  logic              wake_vld_i,
  input  logic [TAG_W-1:0]  wake_tag_i,
  input  logic [LAT_W-1:0]  wake_lat_i,
  input  logic [SLOT_W-1:0] wake_slot_i,
  input  logic              kill_i,
  input  logic [N_SLOT-1:0] cmpl_i,
  input  logic              poison_i,
  output logic              rdy_o,
  output logic              drop_o
);

  function automatic logic [LAT_W-1:0] timer_tick(input logic [LAT_W-1:0] t);
    return (t == '0) ? '0 : t - LAT_W'(1);
  endfunction

  function automatic logic producer_clean(input logic [N_SLOT-1:0] cmpl,
                                          input logic [SLOT_W-1:0] slot,
                                          input logic poison);
    return cmpl[slot] & ~poison;
  endfunction

  logic [TAG_W-1:0]  tag_q;
  logic              rdy_q;
  logic [LAT_W-1:0]  timer_q;
  logic [SLOT_W-1:0] slot_q;

  opnd_phase_e phase_w;
  logic        counting_w;
  logic        expire_w;
  logic        kill_hit_w;
  logic        clean_w;
  logic        rdy_after_kill_w;
  logic        reval_w;
  logic        rdy_after_check_w;
  logic        match_w;

  assign counting_w        = (timer_q != '0);
  assign phase_w           = phase_of(rdy_q, counting_w);
  assign expire_w          = (timer_q == LAT_W'(1));
  assign kill_hit_w        = kill_i && (phase_w == PH_SPEC);
  assign clean_w           = producer_clean(cmpl_i, slot_q, poison_i);
  assign rdy_after_kill_w  = rdy_q && !kill_hit_w;
  assign reval_w           = expire_w && !rdy_after_kill_w && clean_w;
  assign rdy_after_check_w = rdy_after_kill_w || reval_w;
  assign match_w           = wake_vld_i && (wake_tag_i == tag_q) && !rdy_after_check_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= '0;
      rdy_q   <= 1'b0;
      timer_q <= '0;
      slot_q  <= '0;
    end else if (alloc_i) begin
      tag_q   <= alloc_tag_i;
      rdy_q   <= alloc_rdy_i;
      timer_q <= '0;
      slot_q  <= '0;
    end else begin
      rdy_q   <= rdy_after_check_w || match_w;
      timer_q <= match_w ? wake_lat_i : timer_tick(timer_q);
      if (match_w) slot_q <= wake_slot_i;
    end
  end

  assign rdy_o  = rdy_q;
  assign drop_o = kill_hit_w && !reval_w && !alloc_i;

  AST_MATCH_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (match_w && !alloc_i) |=> (rdy_q && timer_q == $past(wake_lat_i))) // R1
    else $error("wakeup match did not make operand ready");

  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_i && counting_w && !reval_w && !match_w && !alloc_i) |=> !rdy_q) // R2
    else $error("kill left a counting operand ready");

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (counting_w && !match_w && !alloc_i) |=> (timer_q == $past(timer_q) - LAT_W'(1))) // R3
    else $error("countdown did not step by one");

  AST_REVAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (reval_w && !alloc_i) |=> rdy_q) // R5
    else $error("clean expiry did not revalidate");

  AST_DIRTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && (!rdy_q || kill_i) && !clean_w && !match_w && !alloc_i) |=> !rdy_q) // R5
    else $error("unclean producer revalidated an operand");

endmodule

// File: rtl/sr_issue_ctl.sv
module sr_issue_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic alloc_i,
  input  logic free_i,
  input  logic grant_i,
  input  logic both_rdy_i,
  input  logic drop_i,
  output logic req_o
);

  logic vld_q;
  logic iss_q;
  logic grant_take_w;

  assign req_o        = vld_q && !iss_q && both_rdy_i;
  assign grant_take_w = grant_i && req_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      iss_q <= 1'b0;
    end else if (alloc_i) begin
      vld_q <= 1'b1;
      iss_q <= 1'b0;
    end else begin
      if (free_i) vld_q <= 1'b0;
      if (drop_i) iss_q <= 1'b0;
      else if (grant_take_w) iss_q <= 1'b1;
    end
  end

  AST_GRANT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_take_w && !drop_i && !alloc_i) |=> !req_o) // R8
    else $error("request stayed high after grant");

  AST_FREE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (free_i && !alloc_i) |=> !req_o) // R10
    else $error("request survived free");

endmodule

// File: rtl/sr_replay_entry.sv
module sr_replay_entry
  import sr_pkg::*;
#(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned LAT_W  = 3,
  parameter int unsigned N_SLOT = 4,
  localparam int unsigned SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_i,
  input  logic [N_OPND-1:0][TAG_W-1:0] alloc_tag_i,
  input  logic [N_OPND-1:0]            alloc_rdy_i,
  input  logic                         free_i,
  input  logic                         wake_vld_i,
  input  logic [TAG_W-1:0]             wake_tag_i,
  input  logic [LAT_W-1:0]             wake_lat_i,
  input  logic [SLOT_W-1:0]            wake_slot_i,
  input  logic                         kill_i,
  input  logic [N_SLOT-1:0]            cmpl_i,
  input  logic [N_OPND-1:0]            poison_i,
  input  logic                         grant_i,
  output logic                         req_o,
  output logic [N_OPND-1:0]            opnd_rdy_o
);

  logic [N_OPND-1:0] rdy_w;
  logic [N_OPND-1:0] drop_w;
  logic              both_rdy_w;
  logic              any_drop_w;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    sr_operand #(
      .TAG_W (TAG_W),
      .LAT_W (LAT_W),
      .N_SLOT(N_SLOT)
    ) u_opnd (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (alloc_i),
      .alloc_tag_i(alloc_tag_i[g]),
      .alloc_rdy_i(alloc_rdy_i[g]),
      .wake_vld_i (wake_vld_i),
      .wake_tag_i (wake_tag_i),
      .wake_lat_i (wake_lat_i),
      .wake_slot_i(wake_slot_i),
      .kill_i     (kill_i),
      .cmpl_i     (cmpl_i),
      .poison_i   (poison_i[g]),
      .rdy_o      (rdy_w[g]),
      .drop_o     (drop_w[g])
    );
  end

  assign both_rdy_w = &rdy_w;
  assign any_drop_w = |drop_w;

  sr_issue_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_i   (alloc_i),
    .free_i    (free_i),
    .grant_i   (grant_i),
    .both_rdy_i(both_rdy_w),
    .drop_i    (any_drop_w),
    .req_o     (req_o)
  );

  assign opnd_rdy_o = rdy_w;

  AST_REQ_NEEDS_OPNDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (&opnd_rdy_o)) // R7
    else $error("request raised with an operand not ready");

  AST_DROP_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (any_drop_w && !alloc_i) |=> !req_o) // R8
    else $error("request high right after an operand was dropped");

endmodule

// File: tb/sr_replay_entry_bench.sv
module sr_replay_entry_bench;

  localparam int unsigned TAG_W  = 6;
  localparam int unsigned LAT_W  = 3;
  localparam int unsigned N_SLOT = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_i;
  logic [1:0][TAG_W-1:0] alloc_tag_i;
  logic [1:0] alloc_rdy_i;
  logic free_i;
  logic wake_vld_i;
  logic [TAG_W-1:0] wake_tag_i;
  logic [LAT_W-1:0] wake_lat_i;
  logic [1:0] wake_slot_i;
  logic kill_i;
  logic [N_SLOT-1:0] cmpl_i;
  logic [1:0] poison_i;
  logic grant_i;
  logic req_o;
  logic [1:0] opnd_rdy_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sr_replay_entry #(.TAG_W(TAG_W), .LAT_W(LAT_W), .N_SLOT(N_SLOT)) u_sr_replay_entry (
    .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .alloc_tag_i(alloc_tag_i),
    .alloc_rdy_i(alloc_rdy_i), .free_i(free_i), .wake_vld_i(wake_vld_i),
    .wake_tag_i(wake_tag_i), .wake_lat_i(wake_lat_i), .wake_slot_i(wake_slot_i),
    .kill_i(kill_i), .cmpl_i(cmpl_i), .poison_i(poison_i), .grant_i(grant_i),
    .req_o(req_o), .opnd_rdy_o(opnd_rdy_o)
  );

  task automatic idle();
    alloc_i = 0; alloc_tag_i = '0; alloc_rdy_i = 0; free_i = 0;
    wake_vld_i = 0; wake_tag_i = 0; wake_lat_i = 0; wake_slot_i = 0;
    kill_i = 0; cmpl_i = 0; poison_i = 0; grant_i = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic check(input string rq, input logic [1:0] rdy_exp, input logic req_exp);
    checks++;
    if (opnd_rdy_o !== rdy_exp || req_o !== req_exp) begin
      failures++;
      $display("FAIL %s: rdy=%b req=%b expected rdy=%b req=%b", rq, opnd_rdy_o, req_o, rdy_exp, req_exp);
    end
  endtask

  task automatic do_alloc(input int t0, input int t1, input logic [1:0] r);
    alloc_i = 1; alloc_tag_i[0] = TAG_W'(t0); alloc_tag_i[1] = TAG_W'(t1); alloc_rdy_i = r;
  endtask

  task automatic do_wake(input int t, input int lat, input int slot);
    wake_vld_i = 1; wake_tag_i = TAG_W'(t); wake_lat_i = LAT_W'(lat); wake_slot_i = 2'(slot);
  endtask

  task automatic t_zero_latency();
    do_alloc(5, 9, 2'b00); cyc(); check("R10 alloc not ready", 2'b00, 0);
    do_wake(5, 0, 1); cyc(); check("R1 wake op0", 2'b01, 0);
    kill_i = 1; cyc(); check("R3 zero latency not killable", 2'b01, 0);
    do_wake(9, 0, 0); cyc(); check("R7 both ready requests", 2'b11, 1);
    grant_i = 1; cyc(); check("R8 grant drops request", 2'b11, 0);
  endtask

  // shared shape: wake op0 lat3 slot2, kill, idle count, expiry with given inputs
  task automatic t_expiry(input logic [N_SLOT-1:0] c_mid, input logic [N_SLOT-1:0] c_exp,
                          input logic p_exp, input logic [1:0] rdy_end, input string rq);
    do_alloc(3, 4, 2'b10); cyc(); check("R10 alloc initial ready", 2'b10, 0);
    do_wake(3, 3, 2); cyc(); check("R1 wake with latency", 2'b11, 1);
    kill_i = 1; cyc(); check("R2 kill clears counting op", 2'b10, 0);
    cmpl_i = c_mid; cyc(); check("R4 completion outside expiry ignored", 2'b10, 0);
    cmpl_i = c_exp; poison_i = {1'b0, p_exp}; cyc(); check(rq, rdy_end, rdy_end == 2'b11);
  endtask

  task automatic t_kill_and_wake();
    do_alloc(7, 8, 2'b00); cyc();
    do_wake(7, 2, 0); cyc(); check("R1 wake op0 slot0", 2'b01, 0);
    kill_i = 1; do_wake(8, 2, 3); cyc(); check("R9 kill first then wake", 2'b10, 0);
    cmpl_i = 4'b0001; cyc(); check("R4 op0 revalidates from slot0", 2'b11, 1);
    kill_i = 1; cyc(); check("R6 kill at expiry without completion", 2'b01, 0);
  endtask

  task automatic t_reissue();
    do_alloc(10, 11, 2'b10); cyc();
    do_wake(10, 3, 1); cyc(); check("R7 request", 2'b11, 1);
    grant_i = 1; cyc(); check("R8 issued", 2'b11, 0);
    kill_i = 1; cyc(); check("R8 kill after issue", 2'b10, 0);
    cmpl_i = 4'b0010; cyc(); check("R8 re-request after revalidation", 2'b11, 1);
  endtask

  task automatic t_kill_at_expiry();
    do_alloc(12, 13, 2'b10); cyc();
    do_wake(12, 1, 0); cyc(); check("R1 wake lat1", 2'b11, 1);
    kill_i = 1; cmpl_i = 4'b0001; cyc(); check("R6 kill at clean expiry", 2'b11, 1);
  endtask

  task automatic t_alloc_free();
    do_alloc(2, 2, 2'b11); cyc(); check("R10 alloc ready", 2'b11, 1);
    free_i = 1; cyc(); check("R10 free drops request", 2'b11, 0);
    do_alloc(2, 2, 2'b00); do_wake(2, 0, 0); cyc(); check("R10 alloc beats wake", 2'b00, 0);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 5000) begin @(posedge clk); wd++; end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R7 reset state", 2'b00, 0);
    rst_n = 1;
    cyc();
    t_zero_latency();
    t_expiry(4'b0100, 4'b0100, 1'b0, 2'b11, "R5 clean expiry revalidates");
    t_expiry(4'b0100, 4'b1011, 1'b0, 2'b10, "R4 other slots ignored");
    do_wake(3, 0, 0); cyc(); check("R5 fresh wakeup after failed check", 2'b11, 1);
    t_expiry(4'b0000, 4'b0100, 1'b1, 2'b10, "R5 poison blocks revalidation");
    t_kill_and_wake();
    t_reissue();
    t_kill_at_expiry();
    t_alloc_free();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule